// File: doc/BRIEF.md
# On-Off-Keyed Pulse-Train Serializer

This block turns a stored list of run lengths into a one-wire on-off-keyed waveform. Each entry of a small duration table gives a number of time steps. Even entries are high runs and odd entries are low runs, so the output alternates high and low. The pace is set by an external divider, which raises a one-cycle step tick. Each tick advances the waveform by exactly one step.

Software, or a neighbouring block, loads the durations through a plain write port. It then presents a pair count, a repeat count and an inter-frame pause measured in steps, and pulses start. The pause lengthens the final low run of the frame. The whole frame, with that stretched tail, is replayed back to back the requested number of times. Entries of length zero are passed over without spending a step. Busy stays high for the whole transmission, and a one-cycle done pulse closes it.

Top module: `ook_pulse_serializer`

## Requirements
- R1: After reset, ook_out, busy and done are all low.
- R2: Pair k occupies table addresses 2k (high run) and 2k+1 (low run). The frame begins at address 0, and each entry drives ook_out to its level for exactly as many step ticks as its value.
- R3: The pause value, in steps, is added to the low run at address 2*pairs-1. No other entry is lengthened.
- R4: The frame is sent cfg_repeats times in a row. The step after the last step of one copy is the first step of the next copy.
- R5: A table entry of value zero (with no pause added to it) produces no step, and the entry after it follows directly.
- R6: A start with zero repeats, zero pairs, or a frame whose total length is zero raises done in the next cycle. In that case busy never rises and ook_out stays low. While busy is low, ook_out is low.
- R7: Busy rises in the cycle after an accepted start. It stays high until the step tick that ends the final step, and it can only fall on a step tick. Done is high for exactly that one cycle, and only while busy is low.
- R8: ook_out changes only at clock edges where step_tick is high. A tick in the same cycle as start emits no step; the first step comes with the next tick.
- R9: While busy, start and table writes are ignored. cfg_pairs, cfg_repeats and cfg_pause are sampled only when a start is accepted.
- R10: A cfg_pairs value above MAX_PAIRS is treated as MAX_PAIRS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | One-cycle strobe that advances the waveform by one step |
| start | input | 1 | Begin a transmission using the current configuration |
| cfg_pairs | input | PAIR_W | Number of high/low pairs in the frame |
| cfg_repeats | input | REP_W | Number of times the frame is sent |
| cfg_pause | input | PAUSE_W | Steps added to the final low run |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table address; even addresses are high runs, odd addresses low runs |
| wr_data | input | DUR_W | Run length in steps |
| ook_out | output | 1 | Serial on-off-keyed output |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle end-of-transmission pulse |

## Verification
Two events can land on the same clock edge. A start can coincide with a step tick, and a start or table write can arrive while a repetition is rolling over into the next copy of the frame. The bench runs one case with a tick on every clock, so every start edge also carries a tick. It then checks that the recorded step sequence still matches the model exactly, with no extra leading step. In a second case it issues a start and a table write in the middle of a multi-repeat frame. It checks that the stream, the number of done pulses and a later replay of the table all show no trace of them.

// File: rtl/ook_ser_pkg.sv
package ook_ser_pkg;

    // Sequencer phases: waiting, emitting runs, holding the final step.
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_TAIL = 2'd2
    } seq_state_e;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ook_dur_table.sv
module ook_dur_table #(
    parameter int ENTRIES = 16,
    parameter int DUR_W   = 12,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_allow,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DUR_W-1:0]                wr_data,
    output logic [ENTRIES-1:0][DUR_W-1:0]   dur
);

    localparam int CNT_W = ADDR_W + 1;

    logic [ENTRIES-1:0]              hit;
    logic [ENTRIES-1:0][DUR_W-1:0]   tab_d;
    logic [ENTRIES-1:0][DUR_W-1:0]   tab_q;

    // One decoded write enable per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_hit
        assign hit[g] = wr_en && wr_allow &&
                        ({1'b0, wr_addr} == CNT_W'(g));
    end

    always_comb begin
        tab_d = tab_q;
        for (int j = 0; j < ENTRIES; j++) begin
            if (hit[j]) begin
                tab_d[j] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign dur = tab_q;

endmodule

// File: rtl/ook_elem_select.sv
module ook_elem_select #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 4,
    parameter int PAIR_W  = 4,
    parameter int DUR_W   = 12,
    parameter int PAUSE_W = 16,
    parameter int LEN_W   = 17
) (
    input  logic [ENTRIES-1:0][DUR_W-1:0]   dur,
    input  logic [PAIR_W-1:0]               pairs,
    input  logic [PAUSE_W-1:0]              pause,
    input  logic [ADDR_W-1:0]               cur_idx,
    output logic                            first_valid,
    output logic [ADDR_W-1:0]               first_idx,
    output logic [LEN_W-1:0]                first_len,
    output logic                            next_valid,
    output logic [ADDR_W-1:0]               next_idx,
    output logic [LEN_W-1:0]                next_len
);

    localparam int CNT_W = ADDR_W + 1;

    logic [CNT_W-1:0]                span;
    logic [ENTRIES-1:0]              live;
    logic [ENTRIES-1:0][LEN_W-1:0]   eff;

    // Number of table entries the frame uses.
    assign span = CNT_W'({pairs, 1'b0});

    // Effective length of each entry: the last one in the frame carries
    // the pause; entries beyond the frame or of zero length are not live.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_eff
        logic in_frame;
        logic is_last;
        assign in_frame = (CNT_W'(g) < span);
        assign is_last  = (CNT_W'(g) + CNT_W'(1)) == span;
        assign eff[g]   = LEN_W'(dur[g]) +
                          (is_last ? LEN_W'(pause) : LEN_W'(0));
        assign live[g]  = in_frame && (eff[g] != '0);
    end

    // Lowest live entry: where every copy of the frame begins.
    always_comb begin
        first_valid = 1'b0;
        first_idx   = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (live[j] && !first_valid) begin
                first_valid = 1'b1;
                first_idx   = ADDR_W'(j);
            end
        end
    end

    // Lowest live entry strictly above the current one.
    always_comb begin
        next_valid = 1'b0;
        next_idx   = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (live[j] && !next_valid && (ADDR_W'(j) > cur_idx)) begin
                next_valid = 1'b1;
                next_idx   = ADDR_W'(j);
            end
        end
    end

    assign first_len = eff[first_idx];
    assign next_len  = eff[next_idx];

endmodule

// File: rtl/ook_seq_ctrl.sv
module ook_seq_ctrl
    import ook_ser_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PAIR_W  = 4,
    parameter int REP_W   = 8,
    parameter int PAUSE_W = 16,
    parameter int LEN_W   = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_tick,
    input  logic                start,
    input  logic [PAIR_W-1:0]   cfg_pairs,
    input  logic [REP_W-1:0]    cfg_repeats,
    input  logic [PAUSE_W-1:0]  cfg_pause,
    input  logic                first_valid,
    input  logic [ADDR_W-1:0]   first_idx,
    input  logic [LEN_W-1:0]    first_len,
    input  logic                next_valid,
    input  logic [ADDR_W-1:0]   next_idx,
    input  logic [LEN_W-1:0]    next_len,
    output logic [ADDR_W-1:0]   cur_idx,
    output logic [PAIR_W-1:0]   pairs_lat,
    output logic [PAUSE_W-1:0]  pause_lat,
    output logic                ook,
    output logic                busy,
    output logic                done
);

    typedef struct packed {
        seq_state_e         state;
        logic [ADDR_W-1:0]  idx;
        logic [LEN_W-1:0]   rem;
        logic [REP_W-1:0]   reps;
        logic [PAIR_W-1:0]  pairs;
        logic [PAUSE_W-1:0] pause;
        logic               ook;
        logic               done;
    } seq_t;

    seq_t s_d;
    seq_t s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            S_IDLE: begin
                if (start) begin
                    if (first_valid && (cfg_repeats != '0)) begin
                        s_d.state = S_RUN;
                        s_d.idx   = first_idx;
                        s_d.rem   = first_len;
                        s_d.reps  = cfg_repeats;
                        s_d.pairs = cfg_pairs;
                        s_d.pause = cfg_pause;
                    end else begin
                        // Nothing to send: close at once.
                        s_d.done = 1'b1;
                    end
                end
            end
            S_RUN: begin
                if (step_tick) begin
                    // Even entries are high, odd entries low.
                    s_d.ook = ~s_q.idx[0];
                    if (s_q.rem > LEN_W'(1)) begin
                        s_d.rem = s_q.rem - LEN_W'(1);
                    end else if (next_valid) begin
                        s_d.idx = next_idx;
                        s_d.rem = next_len;
                    end else if (s_q.reps > REP_W'(1)) begin
                        s_d.reps = s_q.reps - REP_W'(1);
                        s_d.idx  = first_idx;
                        s_d.rem  = first_len;
                    end else begin
                        s_d.state = S_TAIL;
                    end
                end
            end
            S_TAIL: begin
                // Hold the final step for one full tick period.
                if (step_tick) begin
                    s_d.ook   = 1'b0;
                    s_d.state = S_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                s_d.state = S_IDLE;
                s_d.ook   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx   = s_q.idx;
    assign pairs_lat = s_q.pairs;
    assign pause_lat = s_q.pause;
    assign ook       = s_q.ook;
    assign busy      = (s_q.state != S_IDLE);
    assign done      = s_q.done;

endmodule

// File: rtl/ook_pulse_serializer.sv
module ook_pulse_serializer
    import ook_ser_pkg::*;
#(
    parameter int MAX_PAIRS = 8,
    parameter int DUR_W     = 12,
    parameter int REP_W     = 8,
    parameter int PAUSE_W   = 16,
    parameter int ENTRIES   = 2 * MAX_PAIRS,
    parameter int ADDR_W    = $clog2(ENTRIES),
    parameter int PAIR_W    = $clog2(MAX_PAIRS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_tick,
    input  logic                start,
    input  logic [PAIR_W-1:0]   cfg_pairs,
    input  logic [REP_W-1:0]    cfg_repeats,
    input  logic [PAUSE_W-1:0]  cfg_pause,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DUR_W-1:0]    wr_data,
    output logic                ook_out,
    output logic                busy,
    output logic                done
);

    localparam int LEN_W = wider(DUR_W, PAUSE_W) + 1;

    logic [ENTRIES-1:0][DUR_W-1:0] dur;
    logic [PAIR_W-1:0]  pairs_clamped;
    logic [PAIR_W-1:0]  pairs_lat;
    logic [PAIR_W-1:0]  pairs_sel;
    logic [PAUSE_W-1:0] pause_lat;
    logic [PAUSE_W-1:0] pause_sel;
    logic [ADDR_W-1:0]  cur_idx;
    logic               first_valid;
    logic [ADDR_W-1:0]  first_idx;
    logic [LEN_W-1:0]   first_len;
    logic               next_valid;
    logic [ADDR_W-1:0]  next_idx;
    logic [LEN_W-1:0]   next_len;
    logic               busy_i;

    // Pair counts above the table size use the whole table.
    assign pairs_clamped = (cfg_pairs > PAIR_W'(MAX_PAIRS)) ?
                           PAIR_W'(MAX_PAIRS) : cfg_pairs;

    // Live settings while idle, captured settings while sending.
    assign pairs_sel = busy_i ? pairs_lat : pairs_clamped;
    assign pause_sel = busy_i ? pause_lat : cfg_pause;

    ook_dur_table #(
        .ENTRIES (ENTRIES),
        .DUR_W   (DUR_W),
        .ADDR_W  (ADDR_W)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (!busy_i),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dur      (dur)
    );

    ook_elem_select #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .PAIR_W  (PAIR_W),
        .DUR_W   (DUR_W),
        .PAUSE_W (PAUSE_W),
        .LEN_W   (LEN_W)
    ) i_select (
        .dur         (dur),
        .pairs       (pairs_sel),
        .pause       (pause_sel),
        .cur_idx     (cur_idx),
        .first_valid (first_valid),
        .first_idx   (first_idx),
        .first_len   (first_len),
        .next_valid  (next_valid),
        .next_idx    (next_idx),
        .next_len    (next_len)
    );

    ook_seq_ctrl #(
        .ADDR_W  (ADDR_W),
        .PAIR_W  (PAIR_W),
        .REP_W   (REP_W),
        .PAUSE_W (PAUSE_W),
        .LEN_W   (LEN_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_tick   (step_tick),
        .start       (start),
        .cfg_pairs   (pairs_clamped),
        .cfg_repeats (cfg_repeats),
        .cfg_pause   (cfg_pause),
        .first_valid (first_valid),
        .first_idx   (first_idx),
        .first_len   (first_len),
        .next_valid  (next_valid),
        .next_idx    (next_idx),
        .next_len    (next_len),
        .cur_idx     (cur_idx),
        .pairs_lat   (pairs_lat),
        .pause_lat   (pause_lat),
        .ook         (ook_out),
        .busy        (busy_i),
        .done        (done)
    );

    assign busy = busy_i;

endmodule

// File: rtl/ook_serializer_chk.sv
module ook_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic step_tick,
    input logic ook_out,
    input logic busy,
    input logic done
);

    // R8: the line only moves on a step tick.
    a_r8_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(ook_out));

    // R7: a transmission cannot end between ticks.
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_tick) |=> busy);

    // R7: the end of busy is marked by done.
    a_r7_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: done only while idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: an idle line is low.
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ook_out);

endmodule

bind ook_pulse_serializer ook_serializer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .ook_out   (ook_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_ook_pulse_serializer.sv
module test_ook_pulse_serializer;

    localparam int MAX_PAIRS = 8;
    localparam int DUR_W     = 12;
    localparam int REP_W     = 8;
    localparam int PAUSE_W   = 16;
    localparam int ENTRIES   = 2 * MAX_PAIRS;
    localparam int ADDR_W    = $clog2(ENTRIES);
    localparam int PAIR_W    = $clog2(MAX_PAIRS + 1);
    localparam int REC_MAX   = 16384;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_tick = 1'b0;
    logic               start = 1'b0;
    logic [PAIR_W-1:0]  cfg_pairs = '0;
    logic [REP_W-1:0]   cfg_repeats = '0;
    logic [PAUSE_W-1:0] cfg_pause = '0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DUR_W-1:0]   wr_data = '0;
    logic               ook_out;
    logic               busy;
    logic               done;

    ook_pulse_serializer #(
        .MAX_PAIRS (MAX_PAIRS),
        .DUR_W     (DUR_W),
        .REP_W     (REP_W),
        .PAUSE_W   (PAUSE_W)
    ) i_ook_pulse_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_tick   (step_tick),
        .start       (start),
        .cfg_pairs   (cfg_pairs),
        .cfg_repeats (cfg_repeats),
        .cfg_pause   (cfg_pause),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ook_out     (ook_out),
        .busy        (busy),
        .done        (done)
    );

    always #5 clk = ~clk;

    int tests_run = 0;
    int tests_failed = 0;

    // Bench-side model state.
    int tab [ENTRIES];
    bit exp_s [REC_MAX];
    int exp_n;

    // Monitor state (written only by the monitor).
    bit rec [REC_MAX];
    int rec_n = 0;
    int busy_cycles = 0;
    int done_total = 0;
    int r8_viol = 0;
    logic busy_prev = 1'b0;
    logic ook_prev = 1'b0;
    int tcnt = 0;
    int tick_div = 0;

    // Sample away from the active edge, then drive the next tick.
    always @(negedge clk) begin
        if (step_tick && busy_prev && busy) begin
            if (rec_n < REC_MAX) rec[rec_n] = ook_out;
            rec_n++;
        end
        if (rst_n && !step_tick && (ook_out !== ook_prev)) r8_viol++;
        ook_prev  = ook_out;
        busy_prev = busy;
        if (busy) busy_cycles++;
        if (done) done_total++;
        if (tick_div <= 0) begin
            step_tick = 1'b0;
        end else if (tcnt >= tick_div - 1) begin
            step_tick = 1'b1;
            tcnt = 0;
        end else begin
            step_tick = 1'b0;
            tcnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v, input bit shadow);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = DUR_W'(v);
        @(negedge clk);
        wr_en = 1'b0;
        if (shadow) tab[a] = v;
    endtask

    // Expected step list from the requirements (R2..R5, R10).
    task automatic build_exp(input int pairs, input int reps, input int pause);
        int p;
        p = (pairs > MAX_PAIRS) ? MAX_PAIRS : pairs;
        exp_n = 0;
        for (int r = 0; r < reps; r++) begin
            for (int j = 0; j < 2 * p; j++) begin
                int len;
                len = tab[j] + ((j == 2 * p - 1) ? pause : 0);
                for (int k = 0; k < len; k++) begin
                    exp_s[exp_n] = ((j % 2) == 0);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic launch(input int pairs, input int reps, input int pause);
        @(negedge clk);
        cfg_pairs   = PAIR_W'(pairs);
        cfg_repeats = REP_W'(reps);
        cfg_pause   = PAUSE_W'(pause);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic cmp_stream(input string tag, input int base);
        int mism;
        int first_bad;
        mism = 0;
        first_bad = -1;
        chk(rec_n - base == exp_n, {tag, " step count"}, rec_n - base, exp_n);
        for (int i = 0; i < exp_n && (base + i) < rec_n; i++) begin
            if (rec[base + i] != exp_s[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        chk(mism == 0, {tag, " step levels (first bad index)"}, first_bad, -1);
    endtask

    // Launch, wait, check the done/busy handshake (R7) and the stream.
    task automatic run_check(input string tag, input int pairs, input int reps, input int pause);
        int base;
        base = rec_n;
        build_exp(pairs, reps, pause);
        launch(pairs, reps, pause);
        chk(busy == 1'b1, {tag, " R7 busy after start"}, busy, 1);
        wait_done();
        chk(done == 1'b1 && busy == 1'b0, {tag, " R7 done with busy low"}, {busy, done}, 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
        cmp_stream(tag, base);
    endtask

    task automatic t_reset();
        chk(ook_out == 1'b0, "R1 ook_out after reset", ook_out, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
    endtask

    task automatic t_basic();
        tick_div = 3;
        wr(0, 3, 1); wr(1, 2, 1); wr(2, 1, 1); wr(3, 4, 1);
        run_check("R2 basic two pairs", 2, 1, 0);
    endtask

    task automatic t_pause_repeat();
        tick_div = 2;
        run_check("R3 R4 pause and three repeats", 2, 3, 5);
    endtask

    task automatic t_zero_skip();
        tick_div = 3;
        wr(0, 0, 1); wr(1, 2, 1); wr(2, 3, 1); wr(3, 0, 1); wr(4, 2, 1); wr(5, 1, 1);
        run_check("R5 zero entries skipped", 3, 2, 0);
    endtask

    task automatic t_nothing(input string tag, input int pairs, input int reps, input int pause);
        int b0;
        int r0;
        b0 = busy_cycles;
        r0 = rec_n;
        launch(pairs, reps, pause);
        chk(done == 1'b1, {tag, " R6 done next cycle"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done single"}, done, 0);
        chk(busy_cycles == b0, {tag, " R6 busy never rose"}, busy_cycles - b0, 0);
        chk(rec_n == r0 && ook_out == 1'b0, {tag, " R6 no steps"}, rec_n - r0, 0);
    endtask

    task automatic t_zero_cases();
        tick_div = 2;
        t_nothing("zero repeats", 2, 0, 3);
        t_nothing("zero pairs", 0, 2, 3);
        wr(0, 0, 1); wr(1, 0, 1);
        t_nothing("empty frame", 1, 3, 0);
        wr(0, 3, 1); wr(1, 2, 1);
    endtask

    task automatic t_collision();
        tick_div = 1;
        run_check("R8 tick on start edge", 2, 2, 1);
        chk(r8_viol == 0, "R8 output moved without tick", r8_viol, 0);
    endtask

    task automatic t_ignore();
        int base;
        int d0;
        tick_div = 2;
        base = rec_n;
        build_exp(2, 2, 1);
        launch(2, 2, 1);
        repeat (6) @(negedge clk);
        wr(0, 9, 0);
        @(negedge clk);
        cfg_pairs = PAIR_W'(1); cfg_repeats = REP_W'(5); cfg_pause = PAUSE_W'(7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        d0 = done_total;
        wait_done();
        @(negedge clk);
        cmp_stream("R9 start/config/write during busy", base);
        repeat (40) @(negedge clk);
        chk(done_total == d0 + 1, "R9 no second transmission", done_total - d0, 1);
        run_check("R9 table kept old entry", 2, 1, 0);
    endtask

    task automatic t_clamp();
        tick_div = 1;
        for (int j = 0; j < ENTRIES; j++) wr(j, (j % 3) + 1, 1);
        run_check("R10 pair count clamped", 15, 1, 2);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int j = 0; j < ENTRIES; j++) tab[j] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pause_repeat();
        t_zero_skip();
        t_zero_cases();
        t_collision();
        t_ignore();
        t_clamp();
        chk(r8_viol == 0, "R8 output stable between ticks overall", r8_viol, 0);
        summary();
        $finish;
    end

endmodule